// File: doc/BRIEF.md
# Hardwired Step-Decoded Control Unit

The unit drives the control strobes of a processor datapath without microcode. A timing generator walks a one-hot set of steps T0 to T7, one step per clock. A decoder turns the five-bit opcode field of the instruction register into 32 one-hot opcode lines. Each strobe is a fixed sum of products: a step line ANDed with a group of opcode lines, and for branches also with the branch condition bit.

The first three steps are the instruction fetch and are the same for every opcode. From T3 onward the strobes depend on the decoded opcode. The datapath raises an end-of-sequence input at the last step of an instruction, and the generator then returns to T0. The halt opcode freezes the generator and silences every strobe until reset.

Top module: `hwctl_unit`

## Requirements
- R1: An active-low asynchronous reset puts the step generator in T0 (`step_o` = 8'h01) at once, without waiting for a clock edge.
- R2: Without a return request, the step advances by one position on each rising clock edge from T0 to T7. After T7 it goes back to T0. Bit k of `step_o` is step Tk.
- R3: `seq_end_i` sampled high at an edge during T3..T7 returns the step to T0. During T0..T2 it is ignored, so the fetch always runs in full.
- R4: The opcode is `ir_i[15:11]`, and opcode k selects line OPk. The other IR bits have no effect. Fetch strobes are the same for every opcode: T0 asserts `pc_out_o`, `ld_mar_o` and `inc_pc_o`; T1 asserts `ld_pc_o`; T2 asserts `mbr_out_o` and `ld_ir_o`.
- R5: `pc_out_o` = T0 + T3·(OP20 + OP22) + T4·(OP16..OP19).
- R6: `ld_pc_o` = T1 + T5·OP20 + T6·`cond_i`·(OP16..OP19). A branch with the condition low does not load the program counter.
- R7: `ld_mar_o` = T0 + T5·(OP28 + OP29) and `mbr_out_o` = T2 + T7·(OP28 + OP29).
- R8: `rf_to_bus_o` = T3·(OP0..OP14). OP15 does not assert it.
- R9: During T3..T7 with OP31 (halt) decoded, the step holds its value on every edge, even with `seq_end_i` high, and every strobe is 0.
- R10: `step_o` is one-hot at all times.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ir_i | input | 16 | Instruction register contents |
| cond_i | input | 1 | Branch condition bit |
| seq_end_i | input | 1 | Last step of the current instruction |
| step_o | output | 8 | One-hot timing step, bit k = Tk |
| pc_out_o | output | 1 | Program counter drives the bus |
| ld_pc_o | output | 1 | Load program counter |
| ld_mar_o | output | 1 | Load memory address register |
| inc_pc_o | output | 1 | Increment address for the next instruction |
| mbr_out_o | output | 1 | Memory buffer register drives the bus |
| ld_ir_o | output | 1 | Load instruction register |
| rf_to_bus_o | output | 1 | Register file drives the bus |

## Verification
The bench runs each group of opcodes through its full step sequence and checks the step and all seven strobes in every cycle.

- Branch opcodes are run with the condition both high and low. A design that ignored the condition at T6 would load the program counter on a branch that is not taken.
- OP14 and OP15 bracket the edge of the register-file bus group. An off-by-one range would show up on one of them.
- The end-of-sequence input is held high during fetch. A generator that honoured it there would restart before the instruction is loaded.
- A memory opcode runs to T7. This checks the automatic wrap to T0.
- Halt is held for several edges with an end-of-sequence request, followed by a reset in the middle of a cycle. This exposes a halt that leaks past a return request, and a reset that waits for a clock edge.

// File: rtl/hwctl_pkg.sv
package hwctl_pkg;
  parameter int IR_W        = 16;
  parameter int OPC_W       = 5;
  parameter int OPC_LSB     = 11;
  parameter int N_OPS       = 1 << OPC_W;
  parameter int N_STEPS     = 8;
  parameter int FETCH_STEPS = 3;
  parameter int HALT_OP     = N_OPS - 1;

  typedef struct packed {
    logic pc_out;
    logic ld_pc;
    logic ld_mar;
    logic inc_pc;
    logic mbr_out;
    logic ld_ir;
    logic rf_to_bus;
  } strobe_t;

  // one bit per opcode line in [lo, hi]
  function automatic logic [N_OPS-1:0] op_range(input int lo, input int hi);
    logic [N_OPS-1:0] m;
    m = '0;
    for (int k = 0; k < N_OPS; k++)
      if (k >= lo && k <= hi) m[k] = 1'b1;
    return m;
  endfunction
endpackage

// File: rtl/hwctl_opc_dec.sv
module hwctl_opc_dec #(
  parameter int OPC_W = 5,
  localparam int N_OPS = 1 << OPC_W
) (
  input  logic [OPC_W-1:0] opc_i,
  output logic [N_OPS-1:0] op_o
);
  for (genvar g = 0; g < N_OPS; g++) begin : g_line
    assign op_o[g] = (opc_i == OPC_W'(g));
  end
endmodule

// File: rtl/hwctl_step_gen.sv
module hwctl_step_gen #(
  parameter int N_STEPS     = 8,
  parameter int FETCH_STEPS = 3
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               hold_i,
  input  logic               seq_end_i,
  output logic [N_STEPS-1:0] step_o
);
  localparam logic [N_STEPS-1:0] FIRST = N_STEPS'(1);

  logic [N_STEPS-1:0] step_q, step_d;
  logic               in_exec;

  assign in_exec = ~|step_q[FETCH_STEPS-1:0];

  always_comb begin
    if (hold_i)
      step_d = step_q;
    else if (step_q[N_STEPS-1] || (seq_end_i && in_exec))
      step_d = FIRST;
    else
      step_d = step_q << 1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) step_q <= FIRST;
    else         step_q <= step_d;
  end

  assign step_o = step_q;

  // R10
  step_onehot_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot(step_q));

  // R2
  step_wrap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (step_q[N_STEPS-1] && !hold_i) |=> step_q[0]);

  // R3
  fetch_no_return_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (step_q[0] && seq_end_i) |=> step_q[1]);

  // R9
  hold_stable_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hold_i |=> $stable(step_q));
endmodule

// File: rtl/hwctl_strobe_logic.sv
module hwctl_strobe_logic
  import hwctl_pkg::*;
(
  input  logic [N_STEPS-1:0] step_i,
  input  logic [N_OPS-1:0]   op_i,
  input  logic               cond_i,
  input  logic               halt_i,
  output strobe_t            strobe_o
);
  localparam logic [N_OPS-1:0] M_JMP   = op_range(20, 20);
  localparam logic [N_OPS-1:0] M_PCSV  = op_range(20, 20) | op_range(22, 22);
  localparam logic [N_OPS-1:0] M_BR    = op_range(16, 19);
  localparam logic [N_OPS-1:0] M_MEM   = op_range(28, 29);
  localparam logic [N_OPS-1:0] M_RFBUS = op_range(0, 14);

  logic g_jmp, g_pcsv, g_br, g_mem, g_rfbus;
  strobe_t raw;

  assign g_jmp   = |(op_i & M_JMP);
  assign g_pcsv  = |(op_i & M_PCSV);
  assign g_br    = |(op_i & M_BR);
  assign g_mem   = |(op_i & M_MEM);
  assign g_rfbus = |(op_i & M_RFBUS);

  always_comb begin
    raw.pc_out    = step_i[0] | (step_i[3] & g_pcsv) | (step_i[4] & g_br);
    raw.ld_pc     = step_i[1] | (step_i[5] & g_jmp) | (step_i[6] & cond_i & g_br);
    raw.ld_mar    = step_i[0] | (step_i[5] & g_mem);
    raw.inc_pc    = step_i[0];
    raw.mbr_out   = step_i[2] | (step_i[7] & g_mem);
    raw.ld_ir     = step_i[2];
    raw.rf_to_bus = step_i[3] & g_rfbus;
    strobe_o      = halt_i ? '0 : raw;
  end
endmodule

// File: rtl/hwctl_unit.sv
module hwctl_unit
  import hwctl_pkg::*;
(
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [IR_W-1:0]    ir_i,
  input  logic               cond_i,
  input  logic               seq_end_i,
  output logic [N_STEPS-1:0] step_o,
  output logic               pc_out_o,
  output logic               ld_pc_o,
  output logic               ld_mar_o,
  output logic               inc_pc_o,
  output logic               mbr_out_o,
  output logic               ld_ir_o,
  output logic               rf_to_bus_o
);
  logic [OPC_W-1:0]   opc;
  logic [N_OPS-1:0]   op;
  logic [N_STEPS-1:0] step;
  logic               halt;
  strobe_t            stb;

  assign opc = ir_i[OPC_LSB +: OPC_W];

  hwctl_opc_dec #(.OPC_W(OPC_W)) u_dec (
    .opc_i (opc),
    .op_o  (op)
  );

  // halt acts only once the instruction is loaded
  assign halt = op[HALT_OP] & ~|step[FETCH_STEPS-1:0];

  hwctl_step_gen #(.N_STEPS(N_STEPS), .FETCH_STEPS(FETCH_STEPS)) u_step (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .hold_i    (halt),
    .seq_end_i (seq_end_i),
    .step_o    (step)
  );

  hwctl_strobe_logic u_stb (
    .step_i   (step),
    .op_i     (op),
    .cond_i   (cond_i),
    .halt_i   (halt),
    .strobe_o (stb)
  );

  assign step_o      = step;
  assign pc_out_o    = stb.pc_out;
  assign ld_pc_o     = stb.ld_pc;
  assign ld_mar_o    = stb.ld_mar;
  assign inc_pc_o    = stb.inc_pc;
  assign mbr_out_o   = stb.mbr_out;
  assign ld_ir_o     = stb.ld_ir;
  assign rf_to_bus_o = stb.rf_to_bus;

  // R9
  halt_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    halt |-> !(pc_out_o | ld_pc_o | ld_mar_o | inc_pc_o | mbr_out_o | ld_ir_o | rf_to_bus_o));

  // R6
  branch_cond_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ld_pc_o && step_o[6]) |-> cond_i);

  // R4
  fetch_ir_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ld_ir_o |=> step_o[3]);
endmodule

// File: tb/hwctl_unit_tb_top.sv
`timescale 1ns/1ps
module hwctl_unit_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [15:0] ir = '0;
  logic       cond = 1'b0;
  logic       seq_end = 1'b0;
  logic [7:0] step;
  logic       pc_out, ld_pc, ld_mar, inc_pc, mbr_out, ld_ir, rf_to_bus;
  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;

  hwctl_unit dut_i (
    .clk_i(clk), .rst_ni(rst_n), .ir_i(ir), .cond_i(cond), .seq_end_i(seq_end),
    .step_o(step), .pc_out_o(pc_out), .ld_pc_o(ld_pc), .ld_mar_o(ld_mar),
    .inc_pc_o(inc_pc), .mbr_out_o(mbr_out), .ld_ir_o(ld_ir), .rf_to_bus_o(rf_to_bus)
  );

  // strobe order: pc_out ld_pc ld_mar inc_pc mbr_out ld_ir rf_to_bus
  function automatic logic [6:0] strb();
    return {pc_out, ld_pc, ld_mar, inc_pc, mbr_out, ld_ir, rf_to_bus};
  endfunction

  task automatic check(input string req, input logic [7:0] st_exp, input logic [6:0] sb_exp);
    checks++;
    if (step !== st_exp || strb() !== sb_exp) begin
      errors++;
      $display("FAIL %s step=%h/%b expected %h/%b", req, step, strb(), st_exp, sb_exp);
    end
  endtask

  // {opc[21:17], cond[16], seq_end[15], step[14:7], strobes[6:0]}
  localparam int NV = 50;
  localparam logic [21:0] VEC [NV] = '{
    // R8 add: fetch then register-file bus at T3, return
    {5'd0,1'b0,1'b0,8'h01,7'b1011000}, {5'd0,1'b0,1'b0,8'h02,7'b0100000},
    {5'd0,1'b0,1'b0,8'h04,7'b0000110}, {5'd0,1'b0,1'b1,8'h08,7'b0000001},
    // R5 R6 OP20
    {5'd20,1'b0,1'b0,8'h01,7'b1011000}, {5'd20,1'b0,1'b0,8'h02,7'b0100000},
    {5'd20,1'b0,1'b0,8'h04,7'b0000110}, {5'd20,1'b0,1'b0,8'h08,7'b1000000},
    {5'd20,1'b0,1'b0,8'h10,7'b0000000}, {5'd20,1'b0,1'b1,8'h20,7'b0100000},
    // R6 branch taken OP17
    {5'd17,1'b0,1'b0,8'h01,7'b1011000}, {5'd17,1'b0,1'b0,8'h02,7'b0100000},
    {5'd17,1'b0,1'b0,8'h04,7'b0000110}, {5'd17,1'b1,1'b0,8'h08,7'b0000000},
    {5'd17,1'b1,1'b0,8'h10,7'b1000000}, {5'd17,1'b1,1'b0,8'h20,7'b0000000},
    {5'd17,1'b1,1'b1,8'h40,7'b0100000},
    // R6 branch not taken OP18
    {5'd18,1'b0,1'b0,8'h01,7'b1011000}, {5'd18,1'b0,1'b0,8'h02,7'b0100000},
    {5'd18,1'b0,1'b0,8'h04,7'b0000110}, {5'd18,1'b0,1'b0,8'h08,7'b0000000},
    {5'd18,1'b0,1'b0,8'h10,7'b1000000}, {5'd18,1'b0,1'b0,8'h20,7'b0000000},
    {5'd18,1'b0,1'b1,8'h40,7'b0000000},
    // R7 R2 OP28 runs to T7 and wraps
    {5'd28,1'b0,1'b0,8'h01,7'b1011000}, {5'd28,1'b0,1'b0,8'h02,7'b0100000},
    {5'd28,1'b0,1'b0,8'h04,7'b0000110}, {5'd28,1'b0,1'b0,8'h08,7'b0000000},
    {5'd28,1'b0,1'b0,8'h10,7'b0000000}, {5'd28,1'b0,1'b0,8'h20,7'b0010000},
    {5'd28,1'b0,1'b0,8'h40,7'b0000000}, {5'd28,1'b0,1'b0,8'h80,7'b0000100},
    // R5 OP22
    {5'd22,1'b0,1'b0,8'h01,7'b1011000}, {5'd22,1'b0,1'b0,8'h02,7'b0100000},
    {5'd22,1'b0,1'b0,8'h04,7'b0000110}, {5'd22,1'b0,1'b1,8'h08,7'b1000000},
    // R3 seq_end held in fetch is ignored; R8 OP14 top of range
    {5'd14,1'b0,1'b1,8'h01,7'b1011000}, {5'd14,1'b0,1'b1,8'h02,7'b0100000},
    {5'd14,1'b0,1'b0,8'h04,7'b0000110}, {5'd14,1'b0,1'b1,8'h08,7'b0000001},
    // R8 OP15 outside range
    {5'd15,1'b0,1'b0,8'h01,7'b1011000}, {5'd15,1'b0,1'b0,8'h02,7'b0100000},
    {5'd15,1'b0,1'b0,8'h04,7'b0000110}, {5'd15,1'b0,1'b1,8'h08,7'b0000000},
    // R9 halt: fetch normal, then frozen at T3 even with seq_end
    {5'd31,1'b0,1'b0,8'h01,7'b1011000}, {5'd31,1'b0,1'b0,8'h02,7'b0100000},
    {5'd31,1'b0,1'b0,8'h04,7'b0000110}, {5'd31,1'b0,1'b0,8'h08,7'b0000000},
    {5'd31,1'b0,1'b0,8'h08,7'b0000000}, {5'd31,1'b0,1'b1,8'h08,7'b0000000}
  };

  initial begin : watchdog
    #(200000 * 20);
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin : main
    #25;
    // R1 reset state
    check("R1 reset", 8'h01, 7'b1011000);
    @(negedge clk);
    rst_n = 1'b1;
    for (int i = 0; i < NV; i++) begin
      ir      = {VEC[i][21:17], 11'(i * 37)}; // R4 low IR bits vary
      cond    = VEC[i][16];
      seq_end = VEC[i][15];
      #1;
      check("R2-R9 vector", VEC[i][14:7], VEC[i][6:0]);
      @(negedge clk);
    end
    // R9 still frozen after more edges
    ir = {5'd31, 11'h7ff}; seq_end = 1'b1;
    repeat (3) @(negedge clk);
    #1 check("R9 hold", 8'h08, 7'b0000000);
    // R1 asynchronous reset mid-cycle
    #3 rst_n = 1'b0;
    #1 check("R1 async", 8'h01, 7'b1011000);
    @(negedge clk);
    rst_n = 1'b1; seq_end = 1'b0; ir = {5'd16, 11'h0}; cond = 1'b1;
    repeat (6) @(negedge clk);
    #1 check("R6 OP16 taken", 8'h40, 7'b0100000);
    @(negedge clk);
    #1 check("R2 T7 no strobe", 8'h80, 7'b0000000);
    @(negedge clk);
    #1 check("R2 wrap", 8'h01, 7'b1011000);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule